// File: doc/BRIEF.md
# Top-of-Book Price Level Tracker

This block keeps the resting-order state of one instrument's limit order book in on-chip memory. Commands arrive one at a time on a valid/ready handshake. An add command stores a new order in an order table and grows the aggregate at its price level. An execute command consumes quantity from a stored order and shrinks its level. The block also keeps the highest bid price, the lowest ask price and the total resting quantity on each side. All of these are registered outputs, so downstream logic can read them at any time.

Orders go into a direct-mapped table. The slot is the order ID taken modulo the table depth, which is a power of two. Price levels go into one direct-mapped table per side, indexed by the price's offset from a configured base price. Every command takes the same fixed number of cycles. The order slot is read first, then the level entry, and both are written back in the last cycle. The best prices are only ever improved, by a single compare-and-replace on each add. When a level empties, the best price is not searched for again.

When a command finishes, the block pulses a completion flag for one cycle. With it come an error flag and the updated remaining size, status, level total and level order count of the entry that was touched.

Top module: `lob_level_tracker`

## Requirements
- R1: After reset the best bid is 0 and the best ask is all ones. Both side totals are 0, `cmd_ready` is 1 and `done` is 0.
- R2: An in-range buy add replaces the best bid only when its price is strictly higher than the best bid. An in-range sell add replaces the best ask only when its price is strictly lower than the best ask. Execute commands leave both best prices unchanged.
- R3: An accepted add stores the ID, price, side and size in its slot, with a remaining size equal to the size and status 1 (new). The response reports that remaining size and status. Status codes are: 0 empty, 1 new, 2 filled.
- R4: An accepted add raises its level's total by the size, its level's order count by one, and the total of its side by the size. The response reports the new level total and count.
- R5: The order slot is the order ID modulo `ORD_DEPTH`. A later add whose ID shares the slot replaces the stored order, and an execute that names the replaced ID is then rejected.
- R6: An accepted execute applies min(quantity, remaining). That amount is taken from the order's remaining size, from the total of the order's stored price level and side, and from that side's total. The remaining size therefore saturates at 0, and the level order count does not change.
- R7: An execute sets the status to 2 (filled) when the remaining size before it is less than or equal to the executed quantity. Otherwise the status is unchanged.
- R8: `cmd_op` 0 means add and 1 means execute. `cmd_side` 0 means buy and 1 means sell.
- R9: An add is accepted only if `PRICE_BASE <= price < PRICE_BASE + LVL_DEPTH`; its level index is price minus `PRICE_BASE`. Any other add completes with `err` = 1 and changes no state.
- R10: An execute whose slot is empty (status 0), or whose slot holds a different ID, completes with `err` = 1 and changes no state.
- R11: `done` is high in the third cycle after the accepting clock edge, for one cycle. `cmd_ready` is low from the accepting edge until that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted on this edge if valid |
| cmd_op | input | 1 | 0 add, 1 execute |
| cmd_side | input | 1 | 0 buy, 1 sell (add only) |
| cmd_id | input | ID_W | Order ID |
| cmd_price | input | PRICE_W | Limit price (add only) |
| cmd_qty | input | QTY_W | Order size or executed quantity |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completed command was rejected |
| rsp_remaining | output | QTY_W | Remaining size of the touched order |
| rsp_status | output | 2 | Status of the touched order |
| rsp_level_total | output | TOT_W | Total size at the touched level |
| rsp_level_count | output | CNT_W | Order count at the touched level |
| best_bid | output | PRICE_W | Highest bid price seen |
| best_ask | output | PRICE_W | Lowest ask price seen |
| bid_total | output | TOT_W | Resting buy quantity |
| ask_total | output | TOT_W | Resting sell quantity |

## Verification
The bench sweeps adds over every level on both sides. The prices come in a permuted order, so best-price updates are mixed with non-improving adds; this separates a strict comparison from a non-strict one and from a plain overwrite. Executes run with quantities one below, equal to and above the remaining size, followed by a second execute on orders that are already partly or fully filled. These patterns separate saturation from wrap-around and pin down the filled-status boundary. Adds with aliasing IDs, executes on empty and replaced slots, and adds one step outside each end of the price window show that rejected commands leave totals and best prices untouched.

// File: rtl/lob_pkg.sv
package lob_pkg;
  localparam logic OP_ADD  = 1'b0;
  localparam logic OP_EXEC = 1'b1;
  localparam logic SIDE_BUY  = 1'b0;
  localparam logic SIDE_SELL = 1'b1;
  localparam logic [1:0] ST_EMPTY  = 2'd0;
  localparam logic [1:0] ST_NEW    = 2'd1;
  localparam logic [1:0] ST_FILLED = 2'd2;
  typedef enum logic [1:0] {S_IDLE, S_ORD, S_LVL} fsm_e;
endpackage

// File: rtl/lob_sram.sv
module lob_sram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [W-1:0]     mem_q;
  logic             vld_q;

  // storage without reset so it can map to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  // per-entry valid flags give a cleared table after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      vld_q <= 1'b0;
    end else begin
      if (we) vld[waddr] <= 1'b1;
      vld_q <= vld[raddr];
    end
  end

  assign rdata = vld_q ? mem_q : '0;
endmodule

// File: rtl/lob_book_totals.sv
module lob_book_totals
  import lob_pkg::*;
#(
  parameter int PRICE_W = 16,
  parameter int QTY_W   = 16,
  parameter int TOT_W   = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd,
  input  logic               is_add,
  input  logic               side,
  input  logic [PRICE_W-1:0] price,
  input  logic [QTY_W-1:0]   amount,
  output logic [PRICE_W-1:0] best_bid,
  output logic [PRICE_W-1:0] best_ask,
  output logic [TOT_W-1:0]   bid_total,
  output logic [TOT_W-1:0]   ask_total
);
  logic [TOT_W-1:0] amt_ext;
  assign amt_ext = TOT_W'(amount);

  always_ff @(posedge clk) begin
    if (rst) begin
      best_bid  <= '0;
      best_ask  <= '1;
      bid_total <= '0;
      ask_total <= '0;
    end else if (upd) begin
      if (is_add) begin
        if (side == SIDE_BUY) begin
          bid_total <= bid_total + amt_ext;
          if (price > best_bid) best_bid <= price;
        end else begin
          ask_total <= ask_total + amt_ext;
          if (price < best_ask) best_ask <= price;
        end
      end else begin
        if (side == SIDE_BUY) bid_total <= bid_total - amt_ext;
        else                  ask_total <= ask_total - amt_ext;
      end
    end
  end

  // R2
  bid_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    best_bid >= $past(best_bid));
  // R2
  ask_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    best_ask <= $past(best_ask));
  // R6
  totals_move_chk: assert property (@(posedge clk) disable iff (rst)
    (bid_total != $past(bid_total) || ask_total != $past(ask_total)) |-> $past(upd));
  // R2
  best_on_add_chk: assert property (@(posedge clk) disable iff (rst)
    (best_bid != $past(best_bid) || best_ask != $past(best_ask)) |-> $past(upd && is_add));
endmodule

// File: rtl/lob_level_tracker.sv
module lob_level_tracker
  import lob_pkg::*;
#(
  parameter int ID_W       = 16,
  parameter int PRICE_W    = 16,
  parameter int QTY_W      = 16,
  parameter int CNT_W      = 8,
  parameter int ORD_DEPTH  = 64,
  parameter int LVL_DEPTH  = 64,
  parameter int PRICE_BASE = 1000,
  parameter int TOT_W      = QTY_W + CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_op,
  input  logic               cmd_side,
  input  logic [ID_W-1:0]    cmd_id,
  input  logic [PRICE_W-1:0] cmd_price,
  input  logic [QTY_W-1:0]   cmd_qty,
  output logic               done,
  output logic               err,
  output logic [QTY_W-1:0]   rsp_remaining,
  output logic [1:0]         rsp_status,
  output logic [TOT_W-1:0]   rsp_level_total,
  output logic [CNT_W-1:0]   rsp_level_count,
  output logic [PRICE_W-1:0] best_bid,
  output logic [PRICE_W-1:0] best_ask,
  output logic [TOT_W-1:0]   bid_total,
  output logic [TOT_W-1:0]   ask_total
);
  localparam int SLOT_W = $clog2(ORD_DEPTH);
  localparam int LIDX_W = $clog2(LVL_DEPTH);
  localparam int ORD_W  = ID_W + PRICE_W + 1 + 2 * QTY_W + 2;
  localparam int LVL_W  = TOT_W + CNT_W;

  fsm_e               state;
  logic               op_q, side_q, inrange_q, ok_q, lside_q;
  logic [ID_W-1:0]    id_q;
  logic [PRICE_W-1:0] price_q;
  logic [QTY_W-1:0]   qty_q;
  logic [LIDX_W-1:0]  lidx_q;

  // order table read side
  logic [SLOT_W-1:0]  ord_raddr;
  logic [ORD_W-1:0]   ord_rdata, ord_wdata;
  logic               ord_we;
  logic [ID_W-1:0]    o_id;
  logic [PRICE_W-1:0] o_price;
  logic               o_side;
  logic [QTY_W-1:0]   o_qty, o_rem;
  logic [1:0]         o_status;

  // level tables read side
  logic [LIDX_W-1:0]  lvl_addr, use_idx;
  logic [LVL_W-1:0]   lvl_rdata [2];
  logic [LVL_W-1:0]   lvl_wdata;
  logic [1:0]         lvl_we;
  logic [TOT_W-1:0]   l_tot, new_tot;
  logic [CNT_W-1:0]   l_cnt, new_cnt;

  logic               use_side, ex_ok, cmd_inrange;
  logic [QTY_W-1:0]   applied, new_rem;
  logic [1:0]         new_st;

  assign cmd_ready   = (state == S_IDLE);
  assign cmd_inrange = (int'(cmd_price) >= PRICE_BASE) &&
                       (int'(cmd_price) <  PRICE_BASE + LVL_DEPTH);

  assign ord_raddr = (state == S_IDLE) ? cmd_id[SLOT_W-1:0] : id_q[SLOT_W-1:0];
  assign {o_id, o_price, o_side, o_qty, o_rem, o_status} = ord_rdata;

  // stage 1: pick the level from the command (add) or the stored order (execute)
  assign ex_ok    = (o_status != ST_EMPTY) && (o_id == id_q);
  assign use_side = (op_q == OP_ADD) ? side_q : o_side;
  assign use_idx  = (op_q == OP_ADD) ? LIDX_W'(price_q - PRICE_W'(PRICE_BASE))
                                     : LIDX_W'(o_price - PRICE_W'(PRICE_BASE));
  assign lvl_addr = (state == S_ORD) ? use_idx : lidx_q;

  // stage 2: read-modify-write values
  assign {l_tot, l_cnt} = lvl_rdata[lside_q];
  assign applied = (qty_q < o_rem) ? qty_q : o_rem;
  assign new_rem = o_rem - applied;
  assign new_st  = (o_rem <= qty_q) ? ST_FILLED : o_status;

  always_comb begin
    if (op_q == OP_ADD) begin
      ord_wdata = {id_q, price_q, side_q, qty_q, qty_q, ST_NEW};
      new_tot   = l_tot + TOT_W'(qty_q);
      new_cnt   = l_cnt + CNT_W'(1);
    end else begin
      ord_wdata = {o_id, o_price, o_side, o_qty, new_rem, new_st};
      new_tot   = l_tot - TOT_W'(applied);
      new_cnt   = l_cnt;
    end
  end
  assign lvl_wdata = {new_tot, new_cnt};
  assign ord_we    = (state == S_LVL) && ok_q;

  lob_sram #(.W(ORD_W), .DEPTH(ORD_DEPTH)) u_orders (
    .clk(clk), .rst(rst), .raddr(ord_raddr), .rdata(ord_rdata),
    .we(ord_we), .waddr(id_q[SLOT_W-1:0]), .wdata(ord_wdata)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    assign lvl_we[s] = ord_we && (lside_q == s[0]);
    lob_sram #(.W(LVL_W), .DEPTH(LVL_DEPTH)) u_levels (
      .clk(clk), .rst(rst), .raddr(lvl_addr), .rdata(lvl_rdata[s]),
      .we(lvl_we[s]), .waddr(lidx_q), .wdata(lvl_wdata)
    );
  end

  lob_book_totals #(.PRICE_W(PRICE_W), .QTY_W(QTY_W), .TOT_W(TOT_W)) u_totals (
    .clk(clk), .rst(rst), .upd(ord_we), .is_add(op_q == OP_ADD),
    .side(lside_q), .price(price_q),
    .amount((op_q == OP_ADD) ? qty_q : applied),
    .best_bid(best_bid), .best_ask(best_ask),
    .bid_total(bid_total), .ask_total(ask_total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= S_IDLE;
      done            <= 1'b0;
      err             <= 1'b0;
      rsp_remaining   <= '0;
      rsp_status      <= ST_EMPTY;
      rsp_level_total <= '0;
      rsp_level_count <= '0;
      op_q <= 1'b0; side_q <= 1'b0; inrange_q <= 1'b0; ok_q <= 1'b0;
      lside_q <= 1'b0; id_q <= '0; price_q <= '0; qty_q <= '0; lidx_q <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (cmd_valid) begin
          op_q      <= cmd_op;
          side_q    <= cmd_side;
          id_q      <= cmd_id;
          price_q   <= cmd_price;
          qty_q     <= cmd_qty;
          inrange_q <= cmd_inrange;
          state     <= S_ORD;
        end
        S_ORD: begin
          lside_q <= use_side;
          lidx_q  <= use_idx;
          ok_q    <= (op_q == OP_ADD) ? inrange_q : ex_ok;
          state   <= S_LVL;
        end
        S_LVL: begin
          done            <= 1'b1;
          err             <= !ok_q;
          rsp_remaining   <= ok_q ? ord_wdata[QTY_W+1:2] : '0;
          rsp_status      <= ok_q ? ord_wdata[1:0] : ST_EMPTY;
          rsp_level_total <= ok_q ? new_tot : '0;
          rsp_level_count <= ok_q ? new_cnt : '0;
          state           <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R11
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> ##2 done);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (bid_total == $past(bid_total) && ask_total == $past(ask_total)
                       && best_bid == $past(best_bid) && best_ask == $past(best_ask)));
  // R3
  live_status_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (rsp_status == ST_NEW || rsp_status == ST_FILLED));
endmodule

// File: tb/lob_level_tracker_test.sv
module lob_level_tracker_test;
  // encodings (R8): op 0 add, 1 execute; side 0 buy, 1 sell
  localparam int ID_W = 6, PRICE_W = 10, QTY_W = 10, CNT_W = 6;
  localparam int OD = 8, LD = 8, BASE = 100;
  localparam int TOT_W = QTY_W + CNT_W;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_op = 1'b0, cmd_side = 1'b0;
  logic [ID_W-1:0] cmd_id = '0;
  logic [PRICE_W-1:0] cmd_price = '0;
  logic [QTY_W-1:0] cmd_qty = '0;
  logic cmd_ready, done, err;
  logic [QTY_W-1:0] rsp_remaining;
  logic [1:0] rsp_status;
  logic [TOT_W-1:0] rsp_level_total, bid_total, ask_total;
  logic [CNT_W-1:0] rsp_level_count;
  logic [PRICE_W-1:0] best_bid, best_ask;

  always #4 clk = ~clk;

  lob_level_tracker #(.ID_W(ID_W), .PRICE_W(PRICE_W), .QTY_W(QTY_W), .CNT_W(CNT_W),
    .ORD_DEPTH(OD), .LVL_DEPTH(LD), .PRICE_BASE(BASE)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_side(cmd_side), .cmd_id(cmd_id), .cmd_price(cmd_price),
    .cmd_qty(cmd_qty), .done(done), .err(err), .rsp_remaining(rsp_remaining),
    .rsp_status(rsp_status), .rsp_level_total(rsp_level_total),
    .rsp_level_count(rsp_level_count), .best_bid(best_bid), .best_ask(best_ask),
    .bid_total(bid_total), .ask_total(ask_total));

  int n_chk = 0, n_bad = 0;
  int m_id [OD], m_price [OD], m_side [OD], m_rem [OD], m_st [OD];
  int l_tot [2][LD], l_cnt [2][LD];
  int m_bb = 0, m_ba = (1 << PRICE_W) - 1;
  int m_tot [2];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_cmd(input bit op, input bit sd, input int id, input int price, input int qty);
    int slot, li, e_err, e_rem, e_st, e_lt, e_lc, app, os;
    string etag;
    slot = id % OD;
    e_rem = 0; e_st = 0; e_lt = 0; e_lc = 0;
    if (!op) begin
      etag = "R9";
      e_err = (price < BASE || price >= BASE + LD) ? 1 : 0;
      if (e_err == 0) begin
        li = price - BASE;
        m_id[slot] = id; m_price[slot] = price; m_side[slot] = sd;
        m_rem[slot] = qty; m_st[slot] = 1;
        l_tot[sd][li] += qty; l_cnt[sd][li] += 1; m_tot[sd] += qty;
        if (!sd && price > m_bb) m_bb = price;
        if (sd && price < m_ba) m_ba = price;
        e_rem = qty; e_st = 1; e_lt = l_tot[sd][li]; e_lc = l_cnt[sd][li];
      end
    end else begin
      etag = (m_st[slot] != 0 && m_id[slot] != id) ? "R5" : "R10";
      e_err = (m_st[slot] == 0 || m_id[slot] != id) ? 1 : 0;
      if (e_err == 0) begin
        os = m_side[slot]; li = m_price[slot] - BASE;
        app = (qty < m_rem[slot]) ? qty : m_rem[slot];
        if (m_rem[slot] <= qty) m_st[slot] = 2;
        m_rem[slot] -= app; l_tot[os][li] -= app; m_tot[os] -= app;
        e_rem = m_rem[slot]; e_st = m_st[slot]; e_lt = l_tot[os][li]; e_lc = l_cnt[os][li];
      end
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_side = sd;
    cmd_id = ID_W'(id); cmd_price = PRICE_W'(price); cmd_qty = QTY_W'(qty);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11", "ready after accept", int'(cmd_ready), 0);
    chk("R11", "done early", int'(done), 0);
    @(negedge clk);
    chk("R11", "done early", int'(done), 0);
    @(negedge clk);
    chk("R11", "done on time", int'(done), 1);
    chk(etag, "err", int'(err), e_err);
    if (e_err == 0) begin
      chk(op ? "R6" : "R3", "remaining", int'(rsp_remaining), e_rem);
      chk(op ? "R7" : "R3", "status", int'(rsp_status), e_st);
      chk(op ? "R6" : "R4", "level total", int'(rsp_level_total), e_lt);
      chk(op ? "R6" : "R4", "level count", int'(rsp_level_count), e_lc);
    end
    chk("R2 R8", "best bid", int'(best_bid), m_bb);
    chk("R2 R8", "best ask", int'(best_ask), m_ba);
    chk(op ? "R6" : "R4", "bid total", int'(bid_total), m_tot[0]);
    chk(op ? "R6" : "R4", "ask total", int'(ask_total), m_tot[1]);
  endtask

  initial begin
    for (int i = 0; i < OD; i++) begin
      m_id[i] = 0; m_price[i] = 0; m_side[i] = 0; m_rem[i] = 0; m_st[i] = 0;
    end
    for (int s = 0; s < 2; s++) begin
      m_tot[s] = 0;
      for (int i = 0; i < LD; i++) begin l_tot[s][i] = 0; l_cnt[s][i] = 0; end
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "best bid", int'(best_bid), 0);
    chk("R1", "best ask", int'(best_ask), (1 << PRICE_W) - 1);
    chk("R1", "bid total", int'(bid_total), 0);
    chk("R1", "ask total", int'(ask_total), 0);
    chk("R1", "ready", int'(cmd_ready), 1);
    chk("R1", "done", int'(done), 0);

    // R10: execute on empty slot
    run_cmd(1'b1, 1'b0, 5, 0, 3);
    // R2 R3 R4: buys on every level in permuted price order
    for (int k = 0; k < OD; k++) run_cmd(1'b0, 1'b0, k, BASE + (k * 3) % LD, 5 + k);
    // R6 R7: below, equal to and above remaining
    for (int k = 0; k < OD; k++) begin
      int r;
      r = 5 + k;
      run_cmd(1'b1, 1'b0, k, 0, (k % 3 == 0) ? r - 1 : (k % 3 == 1) ? r : r + 3);
    end
    // second execute on partly and fully filled orders (saturation)
    for (int k = 0; k < OD; k++) run_cmd(1'b1, 1'b0, k, 0, 4);
    // R9: out-of-range adds on both sides
    run_cmd(1'b0, 1'b0, 3, BASE - 1, 7);
    run_cmd(1'b0, 1'b1, 3, BASE + LD, 7);
    run_cmd(1'b0, 1'b1, 4, 0, 7);
    run_cmd(1'b0, 1'b0, 4, (1 << PRICE_W) - 1, 7);
    // R5: sells with aliasing IDs replace the buy slots
    for (int k = 0; k < OD; k++) run_cmd(1'b0, 1'b1, OD + k, BASE + (k * 5) % LD, 2 + k);
    run_cmd(1'b1, 1'b0, 0, 0, 1);
    run_cmd(1'b1, 1'b0, 7, 0, 1);
    // repeated adds on one level grow count
    run_cmd(1'b0, 1'b1, 2 * OD, BASE + 4, 6);
    run_cmd(1'b0, 1'b1, 3 * OD, BASE + 4, 9);
    run_cmd(1'b0, 1'b0, 1, BASE + LD - 1, 3);
    run_cmd(1'b0, 1'b0, 2, BASE, 3);
    for (int k = 1; k < OD; k++) run_cmd(1'b1, 1'b0, OD + k, 0, 1 + k);
    run_cmd(1'b1, 1'b0, 3 * OD, 0, 100);
    run_cmd(1'b1, 1'b0, 2 * OD, 0, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule